// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an 8-bit general-purpose I/O port. Software reaches it through a small register bus with three addresses. One register sets the direction of each pin. A second register holds either the value driven on the pin or, when the pin is an input, the request for a pull-up. The third address returns the pin levels after they pass through a synchronizer. For every pin the block drives three outputs to the pad: a data value, an output enable and a pull-up enable.

Reset releases the port without waiting for a clock. While the active-high reset input is asserted, every output enable is forced low through combinational logic, so the pads go to high impedance even if the clock has stopped. The direction and drive registers are cleared on the first clock edge that sees reset.

A debug-enable input forces the pull-ups on a set of pins chosen at build time by a mask. These forced pull-ups ignore the register contents and stay on while reset is asserted, so a debug link on those pins keeps defined levels through reset.

Top module: `gpio_port_ctl`

## Requirements
- R1: After a clocked reset, the direction register (address 0) and the drive register (address 1) both read back 0x00.
- R2: Output enable bit i equals direction bit i. While rst is high, all output enables are 0 at once, with no clock edge needed.
- R3: Pad data bit i always equals drive register bit i.
- R4: A bus write (bus_wr=1) to address 0 or address 1 changes that register on the next rising clock edge. A read of address 0 or 1 returns the register combinationally in the same cycle.
- R5: With rst low, the pull-up for bit i is on exactly when direction bit i is 0 and drive bit i is 1, unless R6 forces it on.
- R6: While dbg_en is 1, the pull-ups on the pins in DBG_PU_MASK (by default bits 5, 3 and 2, value 0x2C) are on whatever the registers and rst hold. When dbg_en is 0 the mask has no effect.
- R7: Reading address 2 returns pin_in delayed by two rising clock edges. A change made between edges is not visible after one edge and is visible after the second.
- R8: Writes to address 2 or address 3 change neither register. Address 3 reads 0x00.
- R9: While rst is high, the pull-ups that come from the registers are off. Only the pull-ups forced under R6 remain on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset. Clears the registers on a clock edge and tri-states the pins with no clock needed |
| dbg_en | input | 1 | Debug enable. Forces the pull-ups on the masked pins |
| bus_addr | input | 2 | Register address: 0 direction, 1 drive, 2 pin levels, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
All 256 direction values are swept. In each step the drive value is a different function of the step and dbg_en alternates, so the pad outputs are checked against a per-bit formula. This separates a mix-up between the direction and drive registers from an inverted term in the pull-up logic, and separates a missing debug mask from a mask that is always applied. Reset is raised in the middle of a clock cycle with output drivers and pull-ups active. This shows whether the tri-state is truly asynchronous and whether the forced pull-ups survive reset. Pin patterns such as walking ones, all-ones and alternating bits are read one edge and two edges after they change, which exposes a synchronizer that is too short or too long.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DRV  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] drv;
    } port_cfg_t;

    typedef struct packed {
        logic data;
        logic oe;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_bit(input logic dir_b, input logic drv_b,
                                         input logic rst_b, input logic forced);
        pad_ctl_t p;
        p.data = drv_b;
        p.oe   = dir_b & ~rst_b;
        p.pu   = (~rst_b & ~dir_b & drv_b) | forced;
        return p;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_port_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] warm_q;
        always_ff @(posedge clk) begin
            if (rst)                 warm_q <= 2'd0;
            else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
        // R7: the synchronized value lags the pin by two edges
        p_two_edge_lag_r7: assert property (@(posedge clk) disable iff (rst)
            (warm_q == 2'd2) |-> (q == $past(d, 2)));
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output port_cfg_t         cfg,
    output logic [PORT_W-1:0] rdata
);
    port_cfg_t cfg_q;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DIR: cfg_q.dir <= wdata;
                SEL_DRV: cfg_q.drv <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR: rdata = cfg_q.dir;
            SEL_DRV: rdata = cfg_q.drv;
            SEL_PIN: rdata = pin_sync;
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    // R4: a write to the direction register lands on the next edge
    p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == SEL_DIR) |=> (cfg_q.dir == $past(wdata)));
    // R4: a write to the drive register lands on the next edge
    p_drv_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == SEL_DRV) |=> (cfg_q.drv == $past(wdata)));
    // R8: writes to the pin and unused addresses leave the registers alone
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == SEL_PIN || addr == SEL_NONE)) |=> $stable(cfg_q));
    // R1: the registers are clear right after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (cfg_q == '0));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] FORCE_MASK = 8'h2C
) (
    input  logic              rst,
    input  logic              dbg_en,
    input  port_cfg_t         cfg,
    output logic [PORT_W-1:0] pad_data,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        pad_ctl_t p;
        assign p = pad_bit(cfg.dir[i], cfg.drv[i], rst, dbg_en & FORCE_MASK[i]);
        assign pad_data[i] = p.data;
        assign pad_oe[i]   = p.oe;
        assign pad_pu[i]   = p.pu;
    end

    always_comb begin
        // R2: nothing drives while reset is high
        if (rst) p_oe_low_in_reset_r2: assert (pad_oe == '0);
        // R6: forced pull-ups hold with debug enabled
        if (dbg_en) p_forced_pu_r6: assert ((pad_pu & FORCE_MASK) == FORCE_MASK);
        // R9: only forced pull-ups remain during reset
        if (rst) p_reset_pu_r9: assert ((pad_pu & ~(dbg_en ? FORCE_MASK : '0)) == '0);
    end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] DBG_PU_MASK = 8'h2C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu
);
    logic [PORT_W-1:0] pin_sync;
    port_cfg_t         cfg;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .cfg      (cfg),
        .rdata    (bus_rdata)
    );

    gpio_pad_ctl #(.FORCE_MASK(DBG_PU_MASK)) u_pad (
        .rst      (rst),
        .dbg_en   (dbg_en),
        .cfg      (cfg),
        .pad_data (pin_out),
        .pad_oe   (pin_oe),
        .pad_pu   (pin_pu)
    );
endmodule

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb;
    localparam logic [7:0] MASK = 8'h2C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbg_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ctl u_dut (
        .clk(clk), .rst(rst), .dbg_en(dbg_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_pu(input logic [7:0] dir, input logic [7:0] drv,
                                          input logic r, input logic dbg);
        return (r ? 8'h00 : (~dir & drv)) | (dbg ? MASK : 8'h00);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] drv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        read(2'd0, rd); check("R1 dir", rd, 8'h00);
        read(2'd1, rd); check("R1 drv", rd, 8'h00);
        check("R2 oe after reset", pin_oe, 8'h00);
        check("R5 pu after reset", pin_pu, 8'h00);

        // R2 R3 R4 R5 R6: sweep all direction values
        for (int v = 0; v < 256; v++) begin
            drv = 8'(v * 37) ^ 8'hA5;
            dbg_en = v[0];
            write(2'd0, 8'(v));
            write(2'd1, drv);
            read(2'd0, rd); check("R4 dir readback", rd, 8'(v));
            read(2'd1, rd); check("R4 drv readback", rd, drv);
            check("R2 oe", pin_oe, 8'(v));
            check("R3 data", pin_out, drv);
            check("R5 R6 pu", pin_pu, exp_pu(8'(v), drv, 1'b0, dbg_en));
        end

        // R4: new value not yet present before the edge
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #0.5 check("R4 before edge", bus_rdata, 8'hFF);
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        #0.5 check("R4 after edge", bus_rdata, 8'h3C);

        // R8: ignored writes
        write(2'd1, 8'h0F);
        write(2'd2, 8'hAA);
        write(2'd3, 8'h55);
        read(2'd0, rd); check("R8 dir kept", rd, 8'h3C);
        read(2'd1, rd); check("R8 drv kept", rd, 8'h0F);
        read(2'd3, rd); check("R8 addr3 reads 0", rd, 8'h00);
        check("R8 oe kept", pin_oe, 8'h3C);

        // R2 R6 R9: asynchronous reset mid-cycle with debug enabled
        write(2'd0, 8'hF0);
        write(2'd1, 8'h0F);
        dbg_en = 1'b1;
        @(posedge clk); #1;
        check("R5 pu before reset", pin_pu, 8'h0F | MASK);
        rst = 1'b1;
        #0.5;
        check("R2 oe async", pin_oe, 8'h00);
        check("R9 pu async", pin_pu, MASK);
        @(posedge clk); @(negedge clk);
        check("R6 pu held in reset", pin_pu, MASK);
        dbg_en = 1'b0;
        #0.5 check("R6 mask off", pin_pu, 8'h00);
        rst = 1'b0;
        read(2'd0, rd); check("R1 dir cleared", rd, 8'h00);
        read(2'd1, rd); check("R1 drv cleared", rd, 8'h00);

        // R7: two-edge synchronizer lag
        for (int k = 0; k < 12; k++) begin
            logic [7:0] prev, nxt;
            prev = pin_in;
            nxt = (k < 8) ? 8'(1 << k) : ((k % 2) ? 8'hFF : 8'h55);
            @(negedge clk);
            bus_addr = 2'd2;
            pin_in = nxt;
            @(posedge clk); @(negedge clk);
            #0.5 check("R7 one edge", bus_rdata, prev);
            @(posedge clk); @(negedge clk);
            #0.5 check("R7 two edges", bus_rdata, nxt);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule